// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block accepts writes to a software-interrupt request register. Each write names an interrupt ID, a target-filter mode and a list of CPUs, and comes with the index of the CPU that issued it. The block works out which CPUs should receive the interrupt. It drops any destination whose CPU interface is turned off. For each remaining destination it sets one pending bit in the 64-bit vector kept for that interrupt ID.

Inside each vector the bits are grouped by requester. Bit `dst + 8*src` means that CPU `src` raised this ID toward CPU `dst`. An acknowledge unit downstream reads these vectors and clears the bits it has consumed through a clear port. Priority arbitration and the interrupt lines to the CPUs belong to other blocks.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every bit of every pending vector is 0.
- R2: Mode 0 (word bits 25:24 = 0) sends the interrupt to the CPUs set in the list field, word bits 23:16, where bit 16+i names CPU i. List bits for CPU indices at or above N_CPU are ignored.
- R3: Mode 1 sends the interrupt to every CPU below N_CPU except the requester, and the list field is ignored.
- R4: Mode 2 sends the interrupt only to the requester, and the list field is ignored.
- R5: A write with mode 3 changes no pending bit.
- R6: The interrupt ID is taken from word bits 3:0. For destination i and requester s, bit i+8*s of that ID's vector is set. No other vector changes.
- R7: A destination whose bit in cpu_en_i is 0 in the write cycle receives no pending bit.
- R8: Pending bits are sticky. A write only sets bits, and a bit stays set until it is cleared.
- R9: With clr_i high, the bits of clr_mask_i are cleared in the vector for clr_id_i. If the same bit is set and cleared in the same cycle, the set wins.
- R10: A write whose requester index is N_CPU or higher changes no pending bit.
- R11: A write strobed at one clock edge is visible on pend_o after that edge. A new write can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Request-register write strobe |
| wr_data_i | input | 32 | Written word: ID in 3:0, list in 23:16, mode in 25:24 |
| src_cpu_i | input | 3 | Index of the requesting CPU |
| cpu_en_i | input | N_CPU | Per-CPU interface enable |
| clr_i | input | 1 | Clear strobe from the acknowledge side |
| clr_id_i | input | ID_W | Vector selected for clearing |
| clr_mask_i | input | 64 | Bits to clear |
| pend_o | output | N_ID*64 | Pending vectors; ID k occupies bits [64k +: 64] |

## Verification
The hardest case to reach is a set and a clear of the same bit of the same vector in one cycle, combined with writes that must be dropped: requester out of range, mode 3, or disabled destinations. Random stimulus rarely lines these up on its own. Directed steps therefore drive a write and a matching clear together, and the random phase takes the clear ID and mask from the most recent write often enough to reach the collision many times. Random phases also cover requesters 4 to 7 and sparse enable masks, and every cycle is compared in full against a bench model.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int MAX_CPU   = 8;
  localparam int STRIDE_LG = 3;
  localparam int VEC_W     = MAX_CPU * MAX_CPU;
  localparam int SRC_W     = 3;
  localparam int LIST_LSB  = 16;
  localparam int MODE_LSB  = 24;

  typedef enum logic [1:0] {
    TGT_LIST   = 2'd0,
    TGT_OTHERS = 2'd1,
    TGT_SELF   = 2'd2,
    TGT_NONE   = 2'd3
  } tgt_mode_e;
endpackage

// File: rtl/sgi_target_sel.sv
module sgi_target_sel
  import sgi_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int ID_W  = 4
) (
  input  logic [31:0]      word_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [N_CPU-1:0] cpu_en_i,
  output logic             ok_o,
  output logic [ID_W-1:0]  id_o,
  output logic [VEC_W-1:0] set_vec_o
);
  tgt_mode_e        mode;
  logic [N_CPU-1:0] self_oh, dest, dest_en;
  logic             src_ok;

  always_comb begin
    mode    = tgt_mode_e'(word_i[MODE_LSB +: 2]);
    self_oh = N_CPU'(1) << src_i;
    src_ok  = 32'(src_i) < N_CPU;
    unique case (mode)
      TGT_LIST:   dest = word_i[LIST_LSB +: N_CPU];
      TGT_OTHERS: dest = ~self_oh;
      TGT_SELF:   dest = self_oh;
      default:    dest = '0;
    endcase
    dest_en   = dest & cpu_en_i;
    ok_o      = src_ok && (mode != TGT_NONE);
    id_o      = word_i[ID_W-1:0];
    // group by requester: stride of MAX_CPU bits per source
    set_vec_o = VEC_W'(dest_en) << (6'(src_i) << STRIDE_LG);
  end
endmodule

// File: rtl/sgi_pend_row.sv
module sgi_pend_row
  import sgi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [VEC_W-1:0] set_vec_i,
  input  logic             clr_i,
  input  logic [VEC_W-1:0] clr_vec_i,
  output logic [VEC_W-1:0] row_o
);
  logic [VEC_W-1:0] set_m, clr_m;

  always_comb begin
    set_m = set_i ? set_vec_i : '0;
    clr_m = clr_i ? clr_vec_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_o <= '0;
    else         row_o <= (row_o & ~clr_m) | set_m;
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_ID  = 16,
  localparam int ID_W = $clog2(N_ID)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [31:0]           wr_data_i,
  input  logic [SRC_W-1:0]      src_cpu_i,
  input  logic [N_CPU-1:0]      cpu_en_i,
  input  logic                  clr_i,
  input  logic [ID_W-1:0]       clr_id_i,
  input  logic [VEC_W-1:0]      clr_mask_i,
  output logic [N_ID*VEC_W-1:0] pend_o
);
  logic             sel_ok;
  logic [ID_W-1:0]  sel_id;
  logic [VEC_W-1:0] sel_vec;

  sgi_target_sel #(.N_CPU(N_CPU), .ID_W(ID_W)) u_sel (
    .word_i    (wr_data_i),
    .src_i     (src_cpu_i),
    .cpu_en_i  (cpu_en_i),
    .ok_o      (sel_ok),
    .id_o      (sel_id),
    .set_vec_o (sel_vec)
  );

  for (genvar k = 0; k < N_ID; k++) begin : g_row
    logic set_k, clr_k;
    assign set_k = wr_i && sel_ok && (32'(sel_id) == k);
    assign clr_k = clr_i && (32'(clr_id_i) == k);
    sgi_pend_row u_row (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_k),
      .set_vec_i (sel_vec),
      .clr_i     (clr_k),
      .clr_vec_i (clr_mask_i),
      .row_o     (pend_o[k*VEC_W +: VEC_W])
    );
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
  import sgi_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_ID  = 16,
  parameter int ID_W  = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_i,
  input logic [31:0]           wr_data_i,
  input logic [SRC_W-1:0]      src_cpu_i,
  input logic                  clr_i,
  input logic [N_ID*VEC_W-1:0] pend_o
);
  function automatic logic [VEC_W-1:0] bad_cols();
    logic [VEC_W-1:0] m = '0;
    for (int s = 0; s < MAX_CPU; s++)
      for (int d = 0; d < MAX_CPU; d++)
        if (s >= N_CPU || d >= N_CPU) m[s*MAX_CPU + d] = 1'b1;
    return m;
  endfunction
  localparam logic [VEC_W-1:0] BAD = bad_cols();

  logic [N_ID*VEC_W-1:0] bad_all;
  always_comb
    for (int k = 0; k < N_ID; k++) bad_all[k*VEC_W +: VEC_W] = BAD;

  // R5
  mode_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i[MODE_LSB +: 2] == 2'd3 && !clr_i) |=> $stable(pend_o));

  // R10
  src_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && 32'(src_cpu_i) >= N_CPU && !clr_i) |=> $stable(pend_o));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  // R11
  no_spont_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((pend_o & ~$past(pend_o)) == '0));

  // R6
  cols_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & bad_all) == '0);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.N_CPU(N_CPU), .N_ID(N_ID), .ID_W(ID_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .wr_data_i (wr_data_i),
  .src_cpu_i (src_cpu_i),
  .clr_i     (clr_i),
  .pend_o    (pend_o)
);

// File: tb/sim_sgi_dispatch.sv
`timescale 1ns/1ps
module sim_sgi_dispatch;
  localparam int NC = 4;
  localparam int NI = 16;

  logic            clk = 0, rst_n = 0;
  logic            wr = 0, clr = 0;
  logic [31:0]     wdata = '0;
  logic [2:0]      src = '0;
  logic [NC-1:0]   en = '1;
  logic [3:0]      cid = '0;
  logic [63:0]     cmask = '0;
  logic [NI*64-1:0] pend;

  logic [63:0] model [NI];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sgi_dispatch #(.N_CPU(NC), .N_ID(NI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata),
    .src_cpu_i(src), .cpu_en_i(en), .clr_i(clr), .clr_id_i(cid),
    .clr_mask_i(cmask), .pend_o(pend)
  );

  function automatic logic [63:0] exp_set(logic [31:0] w, logic [2:0] s, logic [NC-1:0] e);
    logic [63:0] v = '0;
    logic [1:0] md = w[25:24];
    if (s >= NC || md == 2'd3) return v;
    for (int i = 0; i < NC; i++) begin
      bit hit = (md == 2'd0) ? w[16+i] : (md == 2'd1) ? (i != s) : (i == s);
      if (hit && e[i]) v[i + 8*s] = 1'b1;
    end
    return v;
  endfunction

  task automatic compare(string tag);
    checks++;
    for (int k = 0; k < NI; k++)
      if (pend[k*64 +: 64] !== model[k]) begin
        fails++;
        $display("FAIL %s id=%0d got=%h exp=%h", tag, k, pend[k*64 +: 64], model[k]);
        break;
      end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    if (clr) model[cid] = model[cid] & ~cmask;
    if (wr)  model[wdata[3:0]] = model[wdata[3:0]] | exp_set(wdata, src, en);
    @(negedge clk);
    compare(tag);
    wr = 0; clr = 0;
  endtask

  function automatic logic [31:0] mk(int md, logic [7:0] lst, int id);
    return {6'd0, 2'(md), lst, 12'd0, 4'(id)};
  endfunction

  initial begin
    #(200000*8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd41));
    for (int k = 0; k < NI; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);

    // R2: list with bits above N_CPU
    wr = 1; wdata = mk(0, 8'hF5, 3); src = 3'd1; cyc("R2");
    // R3: others, list ignored
    wr = 1; wdata = mk(1, 8'h00, 5); src = 3'd2; cyc("R3");
    // R4: self only
    wr = 1; wdata = mk(2, 8'hFF, 15); src = 3'd3; cyc("R4");
    // R5: mode 3
    wr = 1; wdata = mk(3, 8'hFF, 3); src = 3'd0; cyc("R5");
    // R7: disabled destinations
    en = 4'b0101; wr = 1; wdata = mk(0, 8'h0F, 7); src = 3'd0; cyc("R7");
    en = '1;
    // R10: requester out of range
    wr = 1; wdata = mk(1, 8'hFF, 8); src = 3'd6; cyc("R10");
    // R8: accumulate on same ID
    wr = 1; wdata = mk(0, 8'h02, 3); src = 3'd2; cyc("R8");
    // R9: clear plus simultaneous set of same bit
    clr = 1; cid = 4'd3; cmask = '1;
    wr = 1; wdata = mk(2, 8'h00, 3); src = 3'd1; cyc("R9");
    // R6: ID 0 and ID 15 isolation
    wr = 1; wdata = mk(0, 8'h08, 0); src = 3'd3; cyc("R6");
    // R11: back-to-back writes, one per cycle
    for (int j = 0; j < 6; j++) begin
      wr = 1; wdata = mk(j % 3, 8'(j * 37), j + 9); src = 3'(j % 4);
      cyc("R11");
    end

    for (int n = 0; n < 600; n++) begin
      wr    = ($urandom % 4) != 0;
      wdata = $urandom;
      src   = 3'($urandom % 8);
      en    = ($urandom % 3 == 0) ? NC'($urandom) : '1;
      clr   = ($urandom % 3) == 0;
      if ($urandom % 2) begin
        cid = wdata[3:0]; cmask = exp_set(wdata, src, '1);
      end else begin
        cid = 4'($urandom); cmask = {$urandom, $urandom};
      end
      cyc(src >= NC ? "R10" : (clr ? "R9" : "R6"));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule